// File: doc/BRIEF.md
# Hint-Driven Engine Clock Gate

This block stops and restarts the clocks of several transactional engines. Software sets a permission bit per engine, and that bit is only a hint. Each engine's clock is stopped only while the hint allows it and the engine reports that it is idle. When work arrives, the clock comes back without any software action, and it stops again once the engine goes quiet.

Each engine gets its own gated copy of the input clock. Its enable passes through a level-sensitive cell that only updates while the clock is low, so a gated output never produces a shortened pulse. The idle inputs come from the engines asynchronously and are synchronised before use. A readable status word shows which engine clocks are actually running at any moment. Access is through a simple valid/write/address/data port with combinational read data.

Top module: `hint_clock_gate`

## Requirements
- R1: After reset the hint word reads 0, the status word reads all ones, and every gated clock toggles on every input clock cycle.
- R2: A write to address 0 replaces the hint bits with write data bits [NUM_ENG-1:0]. A read of address 0 returns the hint bits in those positions, and the upper bits read 0.
- R3: A write to address 1 sets each hint bit whose data bit is 1. A write to address 2 clears each hint bit whose data bit is 1. Data bits of 0 leave hints unchanged, and reads of addresses 1 and 2 return 0.
- R4: An engine whose hint bit is 0 has its clock running and its status bit at 1, whatever its idle input does.
- R5: An engine whose hint bit is 1 and whose idle input is high has its clock stopped and its status bit (address 3, bit = engine index) at 0.
- R6: If an engine's idle input is first sampled low at rising edge k while its hint is 1, then the status bit is still 0 just after edges k and k+1, and the gated clock rises again at edge k+2, with the status at 1.
- R7: When that engine's idle input returns high, the clock stops with the same two-edge latency and the status returns to 0, with no register access.
- R8: The gate enable changes only while the input clock is low, so every gated clock high pulse lasts a full half period.
- R9: Gating or releasing one engine's clock has no effect on the clock or status of any other engine.
- R10: Address 3 is read-only. Writes to it change no hint and no status.
- R11: A hint change written at rising edge k first affects the gated clock and status from edge k+1. Just after edge k, the status still shows the old value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock, source of all gated clocks |
| rstN | input | 1 | Active-low asynchronous reset |
| regValid | input | 1 | Register access valid |
| regWrite | input | 1 | 1 = write, 0 = read |
| regAddr | input | ADDR_W | Register address (0 hint, 1 set, 2 clear, 3 status) |
| regWdata | input | DATA_W | Write data |
| regRdata | output | DATA_W | Read data, combinational, 0 when no read is active |
| engIdle | input | NUM_ENG | Asynchronous idle indication per engine |
| gclk | output | NUM_ENG | Gated clock per engine |

## Verification
The checker watches several behaviours on every cycle. It confirms that a cleared hint always keeps the enable on. It confirms that the enable follows the idle input seen two edges earlier whenever the hint is set. It confirms that the enable never moves while the clock is high, and that writes to the hint, set, clear and status addresses update the hint word correctly. The bench scenarios show what only the ports reveal. These are the exact edge at which the status flips after an idle change or a hint write, gated clock edge counts over a window for every engine, no disturbance between engines, and runt-free gated pulses.

// File: rtl/hcg_pkg.sv
package hcg_pkg;

  typedef struct packed {
    logic hintLoad;
    logic hintSet;
    logic hintClr;
    logic selHint;
    logic selStatus;
  } hcgStrobe_t;

  localparam int unsigned ADDR_HINT   = 0;
  localparam int unsigned ADDR_SET    = 1;
  localparam int unsigned ADDR_CLR    = 2;
  localparam int unsigned ADDR_STATUS = 3;

endpackage

// File: rtl/hcg_ctrl.sv
module hcg_ctrl
  import hcg_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              regValid,
  input  logic              regWrite,
  input  logic [ADDR_W-1:0] regAddr,
  output hcgStrobe_t        strobe
);

  logic isHint, isSet, isClr, isStatus;
  logic doWrite, doRead;

  always_comb begin
    isHint   = (regAddr == ADDR_W'(ADDR_HINT));
    isSet    = (regAddr == ADDR_W'(ADDR_SET));
    isClr    = (regAddr == ADDR_W'(ADDR_CLR));
    isStatus = (regAddr == ADDR_W'(ADDR_STATUS));
    doWrite  = regValid && regWrite;
    doRead   = regValid && !regWrite;

    strobe.hintLoad  = doWrite && isHint;
    strobe.hintSet   = doWrite && isSet;
    strobe.hintClr   = doWrite && isClr;
    strobe.selHint   = doRead && isHint;
    strobe.selStatus = doRead && isStatus;
  end

endmodule

// File: rtl/hcg_cell.sv
module hcg_cell (
  input  logic clk,
  input  logic rstN,
  input  logic enReq,
  output logic enHeld,
  output logic gclk
);

  logic enLat;

  // Transparent only while clk is low: the enable seen by the AND gate
  // is frozen for the whole high phase.
  always_latch begin
    if (!rstN)
      enLat = 1'b1;
    else if (!clk)
      enLat = enReq;
  end

  assign enHeld = enLat;
  assign gclk   = clk & enLat;

endmodule

// File: rtl/hcg_datapath.sv
module hcg_datapath
  import hcg_pkg::*;
#(
  parameter int NUM_ENG     = 4,
  parameter int DATA_W      = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  hcgStrobe_t         strobe,
  input  logic [DATA_W-1:0]  regWdata,
  input  logic [NUM_ENG-1:0] engIdle,
  input  logic [NUM_ENG-1:0] gateOn,
  output logic [NUM_ENG-1:0] hintVec,
  output logic [NUM_ENG-1:0] gateReq,
  output logic [DATA_W-1:0]  regRdata
);

  localparam int LAST_STAGE = SYNC_STAGES - 1;

  logic [NUM_ENG-1:0] wrBits;
  logic [NUM_ENG-1:0] syncQ [SYNC_STAGES];
  logic [NUM_ENG-1:0] idleSync;

  assign wrBits = regWdata[NUM_ENG-1:0];

  generate
    if (DATA_W > NUM_ENG) begin : g_spare
      logic unusedWdata;
      assign unusedWdata = ^regWdata[DATA_W-1:NUM_ENG];
    end
  endgenerate

  // Hint register: load, set and clear are mutually exclusive by address.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      hintVec <= '0;
    else if (strobe.hintLoad)
      hintVec <= wrBits;
    else if (strobe.hintSet)
      hintVec <= hintVec | wrBits;
    else if (strobe.hintClr)
      hintVec <= hintVec & ~wrBits;
  end

  // Idle synchroniser chain, reset to "idle".
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      syncQ[0] <= '1;
    else
      syncQ[0] <= engIdle;
  end

  generate
    for (genvar s = 1; s < SYNC_STAGES; s++) begin : g_sync
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)
          syncQ[s] <= '1;
        else
          syncQ[s] <= syncQ[s-1];
      end
    end
  endgenerate

  assign idleSync = syncQ[LAST_STAGE];

  // Clock stays on unless software permits and the engine is idle.
  assign gateReq = ~(hintVec & idleSync);

  always_comb begin
    regRdata = '0;
    if (strobe.selHint)
      regRdata[NUM_ENG-1:0] = hintVec;
    else if (strobe.selStatus)
      regRdata[NUM_ENG-1:0] = gateOn;
  end

endmodule

// File: rtl/hint_clock_gate.sv
module hint_clock_gate
  import hcg_pkg::*;
#(
  parameter int NUM_ENG = 4,
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               regValid,
  input  logic               regWrite,
  input  logic [ADDR_W-1:0]  regAddr,
  input  logic [DATA_W-1:0]  regWdata,
  output logic [DATA_W-1:0]  regRdata,
  input  logic [NUM_ENG-1:0] engIdle,
  output logic [NUM_ENG-1:0] gclk
);

  hcgStrobe_t         strobe;
  logic [NUM_ENG-1:0] hintVec;
  logic [NUM_ENG-1:0] gateReq;
  logic [NUM_ENG-1:0] gateOn;

  hcg_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .regValid (regValid),
    .regWrite (regWrite),
    .regAddr  (regAddr),
    .strobe   (strobe)
  );

  hcg_datapath #(
    .NUM_ENG     (NUM_ENG),
    .DATA_W      (DATA_W),
    .SYNC_STAGES (2)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .regWdata (regWdata),
    .engIdle  (engIdle),
    .gateOn   (gateOn),
    .hintVec  (hintVec),
    .gateReq  (gateReq),
    .regRdata (regRdata)
  );

  generate
    for (genvar e = 0; e < NUM_ENG; e++) begin : g_cell
      hcg_cell u_cell (
        .clk    (clk),
        .rstN   (rstN),
        .enReq  (gateReq[e]),
        .enHeld (gateOn[e]),
        .gclk   (gclk[e])
      );
    end
  endgenerate

endmodule

// File: rtl/hint_clock_gate_chk.sv
module hint_clock_gate_chk #(
  parameter int NUM_ENG = 4,
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 4
) (
  input logic               clk,
  input logic               rstN,
  input logic               regValid,
  input logic               regWrite,
  input logic [ADDR_W-1:0]  regAddr,
  input logic [DATA_W-1:0]  regWdata,
  input logic [NUM_ENG-1:0] engIdle,
  input logic [NUM_ENG-1:0] hintVec,
  input logic [NUM_ENG-1:0] gateOn
);

  logic [1:0]         sinceRst;
  logic [NUM_ENG-1:0] gateOnAtRise;
  logic [NUM_ENG-1:0] wrSlice;

  assign wrSlice = regWdata[NUM_ENG-1:0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sinceRst     <= '0;
      gateOnAtRise <= '1;
    end else begin
      if (sinceRst != 2'd3) sinceRst <= sinceRst + 2'd1;
      gateOnAtRise <= gateOn;
    end
  end

  p_hint_load_r2: assert property (@(posedge clk) disable iff (!rstN)
    (regValid && regWrite && regAddr == ADDR_W'(0)) |=> hintVec == $past(wrSlice));

  p_hint_set_r3: assert property (@(posedge clk) disable iff (!rstN)
    (regValid && regWrite && regAddr == ADDR_W'(1)) |=> hintVec == ($past(hintVec) | $past(wrSlice)));

  p_hint_clr_r3: assert property (@(posedge clk) disable iff (!rstN)
    (regValid && regWrite && regAddr == ADDR_W'(2)) |=> hintVec == ($past(hintVec) & ~$past(wrSlice)));

  p_status_ro_r10: assert property (@(posedge clk) disable iff (!rstN)
    (regValid && regWrite && regAddr == ADDR_W'(3)) |=> $stable(hintVec));

  p_no_glitch_r8: assert property (@(negedge clk) disable iff (!rstN)
    gateOn == gateOnAtRise);

  generate
    for (genvar e = 0; e < NUM_ENG; e++) begin : g_eng
      p_hint_off_runs_r4: assert property (@(posedge clk) disable iff (!rstN)
        !hintVec[e] |-> gateOn[e]);

      p_idle_stops_r5: assert property (@(posedge clk) disable iff (!rstN)
        (sinceRst == 2'd3 && hintVec[e] && $past(engIdle[e], 2)) |-> !gateOn[e]);

      p_busy_runs_r6: assert property (@(posedge clk) disable iff (!rstN)
        (sinceRst == 2'd3 && !$past(engIdle[e], 2)) |-> gateOn[e]);
    end
  endgenerate

endmodule

bind hint_clock_gate hint_clock_gate_chk #(
  .NUM_ENG (NUM_ENG),
  .DATA_W  (DATA_W),
  .ADDR_W  (ADDR_W)
) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .regValid (regValid),
  .regWrite (regWrite),
  .regAddr  (regAddr),
  .regWdata (regWdata),
  .engIdle  (engIdle),
  .hintVec  (hintVec),
  .gateOn   (gateOn)
);

// File: tb/hint_clock_gate_tb.sv
`timescale 1ns/100ps
module hint_clock_gate_tb;

  localparam int N  = 4;
  localparam int DW = 32;
  localparam int AW = 4;
  localparam int WATCHDOG_CYC = 200000;
  localparam int NVEC = 6;

  // {hint, idle, expected status}
  localparam logic [11:0] VEC [NVEC] = '{
    {4'b0000, 4'b1111, 4'b1111},
    {4'b1111, 4'b1111, 4'b0000},
    {4'b1111, 4'b0101, 4'b1010},
    {4'b1010, 4'b1111, 4'b0101},
    {4'b0110, 4'b0011, 4'b1101},
    {4'b1111, 4'b0000, 4'b1111}
  };

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          regValid = 1'b0;
  logic          regWrite = 1'b0;
  logic [AW-1:0] regAddr = '0;
  logic [DW-1:0] regWdata = '0;
  logic [DW-1:0] regRdata;
  logic [N-1:0]  engIdle = '1;
  logic [N-1:0]  gclk;

  int checks = 0;
  int errors = 0;
  int edgeCnt [N];
  int runtCnt [N];
  realtime riseT [N];

  always #2 clk = ~clk;

  hint_clock_gate #(.NUM_ENG(N), .DATA_W(DW), .ADDR_W(AW)) u_dut (
    .clk      (clk),
    .rstN     (rstN),
    .regValid (regValid),
    .regWrite (regWrite),
    .regAddr  (regAddr),
    .regWdata (regWdata),
    .regRdata (regRdata),
    .engIdle  (engIdle),
    .gclk     (gclk)
  );

  for (genvar g = 0; g < N; g++) begin : g_mon
    initial begin
      edgeCnt[g] = 0;
      runtCnt[g] = 0;
      riseT[g]   = -100.0;
    end
    always @(posedge gclk[g]) begin
      edgeCnt[g] = edgeCnt[g] + 1;
      riseT[g]   = $realtime;
    end
    always @(negedge gclk[g]) begin
      if ($realtime - riseT[g] < 1.9) runtCnt[g] = runtCnt[g] + 1;
    end
  end

  task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic writeReg(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    regValid = 1'b1; regWrite = 1'b1; regAddr = a; regWdata = d;
    @(posedge clk);
    #1;
    regValid = 1'b0; regWrite = 1'b0;
  endtask

  task automatic peek(input logic [AW-1:0] a, output logic [DW-1:0] d);
    regValid = 1'b1; regWrite = 1'b0; regAddr = a;
    #0.5;
    d = regRdata;
    regValid = 1'b0;
  endtask

  task automatic readReg(input logic [AW-1:0] a, output logic [DW-1:0] d);
    @(posedge clk);
    #1;
    peek(a, d);
  endtask

  // Returns {mask of engines with 8 edges, mask of engines with 0 edges}.
  task automatic countGclk(output logic [7:0] res);
    int snap [N];
    @(posedge clk);
    #1;
    for (int i = 0; i < N; i++) snap[i] = edgeCnt[i];
    repeat (8) @(posedge clk);
    #1;
    for (int i = 0; i < N; i++) begin
      res[4+i] = (edgeCnt[i] - snap[i] == 8);
      res[i]   = (edgeCnt[i] - snap[i] == 0);
    end
  endtask

  task automatic runAll();
    logic [DW-1:0] rd;
    logic [7:0]    cnt;

    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1'b1;

    // R1 reset state
    readReg(AW'(0), rd);  check("R1 hint after reset", rd, 32'h0);
    readReg(AW'(3), rd);  check("R1 status after reset", rd, 32'hF);
    countGclk(cnt);       check("R1 all clocks toggle", {24'h0, cnt}, {24'h0, 8'hF0});

    // R2 load and readback, upper bits zero
    writeReg(AW'(0), 32'hFFFF_FFF5);
    readReg(AW'(0), rd);  check("R2 hint readback", rd, 32'h5);

    // R3 set and clear aliases
    writeReg(AW'(1), 32'h2);
    readReg(AW'(0), rd);  check("R3 set", rd, 32'h7);
    writeReg(AW'(2), 32'h5);
    readReg(AW'(0), rd);  check("R3 clear", rd, 32'h2);
    readReg(AW'(1), rd);  check("R3 set alias reads zero", rd, 32'h0);

    // R10 status is read-only
    writeReg(AW'(3), 32'h0);
    readReg(AW'(0), rd);  check("R10 hint untouched", rd, 32'h2);
    readReg(AW'(3), rd);  check("R10 status untouched", rd, 32'hD);

    // R11 hint write latency
    writeReg(AW'(0), 32'h0);
    peek(AW'(3), rd);     check("R11 old status just after write edge", rd, 32'hD);
    readReg(AW'(3), rd);  check("R11 new status one edge later", rd, 32'hF);

    // R4 R5 R9 table walk
    for (int v = 0; v < NVEC; v++) begin
      writeReg(AW'(0), {28'h0, VEC[v][11:8]});
      @(negedge clk) engIdle = VEC[v][7:4];
      repeat (3) @(posedge clk);
      readReg(AW'(3), rd);
      check($sformatf("R4/R5 status vector %0d", v), rd, {28'h0, VEC[v][3:0]});
      countGclk(cnt);
      check($sformatf("R9 clock edges vector %0d", v), {24'h0, cnt},
            {24'h0, VEC[v][3:0], ~VEC[v][3:0]});
    end

    // R6 restart latency, R7 automatic stop
    writeReg(AW'(0), 32'hF);
    @(negedge clk) engIdle = 4'hF;
    repeat (4) @(posedge clk);
    readReg(AW'(3), rd);  check("R5 all gated", rd, 32'h0);
    @(negedge clk) engIdle[0] = 1'b0;
    @(posedge clk); #1; peek(AW'(3), rd); check("R6 not yet running at k", rd, 32'h0);
    @(posedge clk); #1; peek(AW'(3), rd); check("R6 not yet running at k+1", rd, 32'h0);
    @(posedge clk); #1; peek(AW'(3), rd); check("R6 running at k+2", rd, 32'h1);
    countGclk(cnt);       check("R9 only engine 0 clocked", {24'h0, cnt}, {24'h0, 8'h1E});
    @(negedge clk) engIdle[0] = 1'b1;
    @(posedge clk); #1; peek(AW'(3), rd); check("R7 still running at k", rd, 32'h1);
    @(posedge clk); #1; peek(AW'(3), rd); check("R7 still running at k+1", rd, 32'h1);
    @(posedge clk); #1; peek(AW'(3), rd); check("R7 stopped at k+2", rd, 32'h0);

    // R8 no runt pulses anywhere
    begin
      int runts = 0;
      for (int i = 0; i < N; i++) runts += runtCnt[i];
      check("R8 runt pulses", runts, 0);
    end
  endtask

  initial begin
    fork
      runAll();
      begin
        repeat (WATCHDOG_CYC) @(posedge clk);
        errors++;
        $display("FAIL watchdog all requirements actual=timeout expected=completion");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule